// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Out

This block shifts or rotates a 32-bit data word by an amount held in a register operand. Four operations are supported: logical left, logical right, arithmetic right and rotate right. Only the low byte of the amount operand is used, so the effective amount runs from 0 to 255. Amounts at or beyond the word width follow fixed rules rather than wrapping.

When the set-flags input is high, the unit also produces a carry-out. This is the last bit shifted out, or a defined value for the out-of-range amounts. When set-flags is low, or when the effective amount is zero, the incoming carry passes through unchanged. The arithmetic is combinational. The top registers the result and the next carry, so both appear one clock after the inputs are sampled.

Top module: `reg_shift_carry`

## Requirements
- R1: `result_o` and `carry_o` show the outcome for the inputs sampled at the previous rising clock edge. While `rst_ni` is low, both outputs are 0.
- R2: Only `amount_i[7:0]` affects the outputs. An amount of 256+k gives the same outputs as an amount of k.
- R3: An effective amount of 0 returns the data unchanged and passes `carry_i` to `carry_o`, for every operation.
- R4: Operation codes are 0 for logical left and 1 for logical right. For amounts 1 to 31 they perform the zero-filling shift. For 32 and above the result is 0.
- R5: Operation code 2 is arithmetic right. For amounts 1 to 31 the sign bit fills from the left. For 32 and above every result bit equals data bit 31.
- R6: Operation code 3 rotates right by the amount modulo 32. A nonzero amount that is a multiple of 32 leaves the data unchanged.
- R7: Logical left carry-out:
  - amounts 1 to 31: data bit (32-n);
  - exactly 32: data bit 0;
  - above 32: 0.
- R8: Logical right carry-out:
  - amounts 1 to 31: data bit (n-1);
  - exactly 32: data bit 31;
  - above 32: 0.
- R9: Arithmetic right carry-out:
  - amounts 1 to 31: data bit (n-1);
  - 32 and above: data bit 31.
- R10: Rotate carry-out, with r the amount modulo 32:
  - r nonzero: data bit (r-1);
  - r zero with a nonzero amount: data bit 31.
- R11: With `set_flags_i` low, `carry_o` equals `carry_i` for every operation and amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Word to shift |
| amount_i | input | 32 | Amount register operand; low byte used |
| op_i | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| set_flags_i | input | 1 | Enables carry-out update |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered shift result |
| carry_o | output | 1 | Registered next carry flag |

## Verification
The bench aims directed vectors at amounts 0, 1, 31, 32, 33, 64 and 255 for each operation, and at amounts above 255 that alias onto small ones. A design that takes the amount modulo 32 for the logical shifts would return a shifted word instead of 0 at 32 and above. A design that picks a carry bit without special-casing would report a stale or wrong bit at exactly 32, or a nonzero carry above 32. A rotate that forgets the case where the amount is a multiple of 32 but not zero would keep the old carry instead of taking bit 31. Random vectors with set-flags toggled catch any path that lets the carry change while flag update is disabled.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'd0,
    OP_LSR = 2'd1,
    OP_ASR = 2'd2,
    OP_ROR = 2'd3
  } shc_op_e;
endpackage

// File: rtl/shc_amount_decode.sv
module shc_amount_decode #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic [SH_W-1:0]  sh_o,
  output logic             zero_o,
  output logic             eq_w_o,
  output logic             ge_w_o
);
  assign sh_o   = amt_i[SH_W-1:0];
  assign zero_o = (amt_i == '0);
  assign eq_w_o = (amt_i == AMT_W'(WIDTH));
  assign ge_w_o = (amt_i >= AMT_W'(WIDTH));
endmodule

// File: rtl/shc_rotator.sv
module shc_rotator #(
  parameter int WIDTH = 32,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stg [SH_W+1];

  assign stg[0] = data_i;
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 2 ** k;
    assign stg[k+1] = sh_i[k] ? {stg[k][D-1:0], stg[k][WIDTH-1:D]} : stg[k];
  end
  assign data_o = stg[SH_W];
endmodule

// File: rtl/shc_core.sv
module shc_core
  import shc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shc_op_e          op_i,
  input  logic             set_flags_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  logic [SH_W-1:0]  sh;
  logic             amt_zero, amt_eq_w, amt_ge_w;
  logic [WIDTH-1:0] data_rev, src, rot, rot_rev, mask;
  logic             sign, bit_out;

  shc_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_dec (
    .amt_i (amt_i),
    .sh_o  (sh),
    .zero_o(amt_zero),
    .eq_w_o(amt_eq_w),
    .ge_w_o(amt_ge_w)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_rev
    assign data_rev[b] = data_i[WIDTH-1-b];
    assign rot_rev[b]  = rot[WIDTH-1-b];
  end

  // left shift runs through the right rotator on the bit-reversed word
  assign src  = (op_i == OP_LSL) ? data_rev : data_i;
  assign sign = data_i[WIDTH-1];
  assign mask = {WIDTH{1'b1}} >> sh;

  shc_rotator #(.WIDTH(WIDTH)) i_rot (
    .data_i(src),
    .sh_i  (sh),
    .data_o(rot)
  );

  // wrapped index: sh==0 selects the top bit, covering amount 32 and rotate multiples
  assign bit_out = src[sh - SH_W'(1)];

  always_comb begin
    result_o = data_i;
    carry_o  = carry_i;
    if (!amt_zero) begin
      unique case (op_i)
        OP_LSL: begin
          result_o = amt_ge_w ? '0 : ({WIDTH{1'b1}} & (rot_rev & {<<{mask}}));
          if (set_flags_i) carry_o = (amt_ge_w && !amt_eq_w) ? 1'b0 : bit_out;
        end
        OP_LSR: begin
          result_o = amt_ge_w ? '0 : (rot & mask);
          if (set_flags_i) carry_o = (amt_ge_w && !amt_eq_w) ? 1'b0 : bit_out;
        end
        OP_ASR: begin
          result_o = amt_ge_w ? {WIDTH{sign}} : ((rot & mask) | ({WIDTH{sign}} & ~mask));
          if (set_flags_i) carry_o = amt_ge_w ? sign : bit_out;
        end
        OP_ROR: begin
          result_o = rot;
          if (set_flags_i) carry_o = bit_out;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/reg_shift_carry.sv
module reg_shift_carry
  import shc_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int OPND_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  data_i,
  input  logic [OPND_W-1:0] amount_i,
  input  logic [1:0]        op_i,
  input  logic              set_flags_i,
  input  logic              carry_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_o
);
  logic [WIDTH-1:0] result_c;
  logic             carry_c;
  logic             primed_q;
  logic             amt_hi_unused;

  assign amt_hi_unused = ^amount_i[OPND_W-1:AMT_W];

  shc_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) i_core (
    .data_i     (data_i),
    .amt_i      (amount_i[AMT_W-1:0]),
    .op_i       (shc_op_e'(op_i)),
    .set_flags_i(set_flags_i),
    .carry_i    (carry_i),
    .result_o   (result_c),
    .carry_o    (carry_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      result_o <= result_c;
      carry_o  <= carry_c;
      primed_q <= 1'b1;
    end
  end

  assert_zero_amount_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(amount_i[AMT_W-1:0]) == '0) |-> (result_o == $past(data_i) && carry_o == $past(carry_i)));

  assert_flags_off_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    !$past(set_flags_i) |-> (carry_o == $past(carry_i)));

  assert_logical_big_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(op_i[1]) == 1'b0 && $past(amount_i[AMT_W-1:0]) >= AMT_W'(WIDTH)) |-> (result_o == '0));

  assert_arith_big_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(op_i) == 2'd2 && $past(amount_i[AMT_W-1:0]) >= AMT_W'(WIDTH))
      |-> (result_o == {WIDTH{$past(data_i[WIDTH-1])}}));

  assert_lsl_over_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(op_i) == 2'd0 && $past(set_flags_i) && $past(amount_i[AMT_W-1:0]) > AMT_W'(WIDTH))
      |-> !carry_o);
endmodule

// File: tb/test_reg_shift_carry.sv
module test_reg_shift_carry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] amount_i = '0;
  logic [1:0]  op_i = '0;
  logic        set_flags_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  reg_shift_carry i_reg_shift_carry (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .amount_i(amount_i),
    .op_i(op_i), .set_flags_i(set_flags_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [32:0] model(logic [31:0] d, logic [31:0] a, logic [1:0] op,
                                        logic sf, logic c);
    int n = int'(a[7:0]);
    int r = n % 32;
    logic [31:0] res;
    logic co;
    res = d; co = c;
    if (n != 0) begin
      case (op)
        2'd0: begin
          if (n < 32) begin res = d << n; co = d[32-n]; end
          else begin res = '0; co = (n == 32) ? d[0] : 1'b0; end
        end
        2'd1: begin
          if (n < 32) begin res = d >> n; co = d[n-1]; end
          else begin res = '0; co = (n == 32) ? d[31] : 1'b0; end
        end
        2'd2: begin
          if (n < 32) begin res = $unsigned($signed(d) >>> n); co = d[n-1]; end
          else begin res = {32{d[31]}}; co = d[31]; end
        end
        default: begin
          if (r == 0) co = d[31];
          else begin res = (d >> r) | (d << (32 - r)); co = d[r-1]; end
        end
      endcase
    end
    if (!sf) co = c;
    return {co, res};
  endfunction

  function automatic string res_tag(logic [31:0] a, logic [1:0] op);
    if (a[7:0] == 8'd0) return "R3";
    case (op)
      2'd0, 2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string cy_tag(logic [31:0] a, logic [1:0] op, logic sf);
    if (!sf) return "R11";
    if (a[7:0] == 8'd0) return "R3";
    case (op)
      2'd0: return "R7";
      2'd1: return "R8";
      2'd2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(logic [31:0] d, logic [31:0] a, logic [1:0] op, logic sf, logic c,
                       string extra);
    logic [32:0] exp;
    @(negedge clk_i);
    data_i = d; amount_i = a; op_i = op; set_flags_i = sf; carry_i = c;
    exp = model(d, a, op, sf, c);
    @(negedge clk_i);
    checks++;
    if (result_o !== exp[31:0]) begin
      errors++;
      $display("FAIL %s%s result op=%0d amt=%0d actual=%h expected=%h",
               res_tag(a, op), extra, op, a, result_o, exp[31:0]);
    end
    checks++;
    if (carry_o !== exp[32]) begin
      errors++;
      $display("FAIL %s%s carry op=%0d amt=%0d actual=%b expected=%b",
               cy_tag(a, op, sf), extra, op, a, carry_o, exp[32]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int amts[10] = '{0, 1, 7, 31, 32, 33, 63, 64, 96, 255};
    void'($urandom(32'h5eed_1234));
    data_i = 32'hdead_beef; carry_i = 1'b1; set_flags_i = 1'b1; amount_i = 32'd4;
    repeat (3) @(negedge clk_i);
    checks++;
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=00000000/0", result_o, carry_o);
    end
    rst_ni = 1'b1;
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 10; k++) begin
        apply(32'h8000_0001, amts[k], op[1:0], 1'b1, 1'b0, "");
        apply(32'h7ffe_0002, amts[k], op[1:0], 1'b1, 1'b1, "");
        apply(32'hc3a5_5a3c, amts[k], op[1:0], 1'b0, 1'b1, "");
      end
      // R2: upper operand bits must not matter
      apply(32'h9234_5678, 32'hffff_ff00, op[1:0], 1'b1, 1'b1, " R2");
      apply(32'h9234_5678, 32'h0000_0105, op[1:0], 1'b1, 1'b0, " R2");
      apply(32'h9234_5678, 32'h1234_5620, op[1:0], 1'b1, 1'b0, " R2");
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a = $urandom();
      if (i % 3 == 0) a[7:0] = a[7:0] & 8'h3f;
      apply($urandom(), a, 2'($urandom()), 1'($urandom()), 1'($urandom()), "");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule